// File: doc/BRIEF.md
# Bus Handshake and Word Transfer Controller

This block moves 16-bit words between a terminal core and an external memory over a shared system data bus. Before it touches the bus it lowers an active-low request. It waits for an active-low grant, and it gives up with a fail flag if the grant does not come within a fixed number of clocks. Once granted, it holds an active-low acknowledge for the whole time it owns the bus. Every word takes three clocks. A read from the system is framed by a three-clock read-enable pulse. A write to the system is marked by a write strobe that is low for one clock.

The core starts an operation with a direction, a burst flag and a word-count field. A transmit operation reads words from the system, and each word gets its own request and acknowledge window. A receive operation drains words that the core has pushed into an internal buffer. Without the burst flag, each buffered word is written in its own window. With the burst flag, the block waits until the whole message is buffered and then writes all of it in one acknowledge window. When the strap input is low, the block also runs one configuration read after reset. During that read an active-terminal output goes low next to the acknowledge. A grant input tied permanently low is handled as a standing grant.

Top module: `dxc_top`

## Requirements
- R1: After reset with `cfg_strap_n` low, exactly one request/grant cycle runs. `term_act_n` is low for the 3 acknowledge clocks of that cycle, the word read is held on `cfg_word`, and `cfg_valid` becomes 1. With the strap high, no request is raised after reset. Right after reset the outputs read: request, acknowledge, both strobes and fail all high (inactive), `busy` 0.
- R2: `bus_ack_n`, `mem_rd_n`, `mem_wr_n` and `sys_dout_en` stay inactive unless the grant was sampled low while the request was low. The acknowledge is never low while the request is high.
- R3: If the grant stays high for `CLK_MHZ*TMO_US` clocks of request, the request is dropped and `hs_fail_n` goes low. No acknowledge occurs. The flag stays low until the next accepted start or a reset.
- R4: A transmit operation and a non-burst receive operation (`op_burst`=0) use one request and one 3-clock acknowledge window per word. `op_burst` has no effect when `op_tx`=1.
- R5: A burst receive (`op_tx`=0, `op_burst`=1) raises its request only after all N words are buffered. It then uses a single request and keeps the acknowledge low for 3*N consecutive clocks.
- R6: Each word written to the system gives a write strobe that is low for exactly one clock, while `sys_dout_en` is 1. Words leave in the order they were pushed with `rx_push`.
- R7: `mem_rd_n` is low for exactly 3 clocks per word read. The captured word is the `sys_din` value at the clock edge that ends the second low clock. It appears on `rd_data` with a one-clock `rd_valid` pulse during the third low clock.
- R8: After releasing the request, the block waits for the grant to be seen high before it starts a new request. If the grant stays low for `TIE_CYC` clocks, it is taken as tied low and the block proceeds. With a tied grant, the request stays high for `TIE_CYC`+1 clocks between words.
- R9: The request is released exactly one clock after the acknowledge returns high.
- R10: A word-count field of 0 means 2^`WC_W` words (32 by default). `cur_wc` shows the index of the word in progress, counting from 0 and stepping once per completed word.
- R11: A start pulse while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low master clear |
| cfg_strap_n | input | 1 | 0 selects the configuration read after reset |
| op_start | input | 1 | One-clock start of an operation |
| op_tx | input | 1 | 1 = transmit (read from system), 0 = receive (write to system) |
| op_burst | input | 1 | Burst write for receive operations |
| op_wc | input | WC_W | Word-count field, 0 means 2^WC_W |
| rx_push | input | 1 | Push one received word into the buffer |
| rx_word | input | DW | Received word |
| rd_data | output | DW | Last word read from the system |
| rd_valid | output | 1 | One-clock pulse: rd_data updated |
| cfg_word | output | DW | Configuration word read after reset |
| cfg_valid | output | 1 | cfg_word holds a read value |
| busy | output | 1 | Operation or configuration read in progress |
| cur_wc | output | WC_W | Index of the word in progress |
| bus_req_n | output | 1 | Active-low bus request |
| bus_gnt_n | input | 1 | Active-low bus grant |
| bus_ack_n | output | 1 | Active-low bus ownership acknowledge |
| term_act_n | output | 1 | Active-low, low during the configuration read |
| hs_fail_n | output | 1 | Active-low grant timeout flag |
| mem_rd_n | output | 1 | Active-low read enable to the system |
| mem_wr_n | output | 1 | Active-low one-clock write strobe |
| sys_din | input | DW | Data from the system bus |
| sys_dout | output | DW | Data to the system bus |
| sys_dout_en | output | 1 | Drive enable for sys_dout |

## Verification
In a non-burst receive, a word from the core can enter the buffer on the same clock edge that a completed write removes the head word. The bench provokes this by waiting for the write strobe of the first word and then pushing the second word at the very edge that ends that word's third clock. The result is judged at the system side. Exactly two write strobes must appear, each in its own acknowledge window, and they must carry the two words in push order. A lost or duplicated count would show up as a missing or repeated word.

// File: rtl/dxc_pkg.sv
package dxc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT_DATA, ST_REQ, ST_XFER, ST_REL, ST_WAIT_HI
  } dxc_state_e;

  typedef enum logic [1:0] {MD_CFG, MD_TX, MD_RX, MD_RXB} dxc_mode_e;

  localparam int unsigned BEATS_PER_WORD = 3;

  // word-count field to number of words; an all-zero field means the maximum
  function automatic int unsigned wc_words(input int unsigned field, input int unsigned width);
    return (field == 0) ? (32'd1 << width) : field;
  endfunction

  function automatic logic mode_writes(input dxc_mode_e m);
    return (m == MD_RX) || (m == MD_RXB);
  endfunction

  function automatic dxc_mode_e pick_mode(input logic tx, input logic burst);
    if (tx) return MD_TX;
    return burst ? MD_RXB : MD_RX;
  endfunction
endpackage

// File: rtl/dxc_cycle_timer.sv
module dxc_cycle_timer #(
  parameter int unsigned LIMIT = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic expired
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt <= '0;
    else if (!en)                    cnt <= '0;
    else if (cnt != CW'(LIMIT - 1))  cnt <= cnt + CW'(1);
  end

  assign expired = en && (cnt == CW'(LIMIT - 1));

  // R3: the count never runs past its terminal value
  a_r3_timer_cap: assert property (@(posedge clk) disable iff (!rst_n)
    en && expired |=> !en || expired);
endmodule

// File: rtl/dxc_rx_fifo.sv
module dxc_rx_fifo #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [DW-1:0]                din,
  input  logic                         pop,
  output logic [DW-1:0]                dout,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign do_push = push && (count != CW'(DEPTH));
  assign do_pop  = pop && (count != '0);
  assign dout    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= ptr_next(wptr);
      if (do_pop)  rptr <= ptr_next(rptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  // R6: a write never takes a word out of an empty buffer
  a_r6_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count != '0);
endmodule

// File: rtl/dxc_word_engine.sv
module dxc_word_engine
  import dxc_pkg::*;
#(
  parameter int unsigned NW_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [NW_W-1:0] nwords,
  output logic [1:0]      phase,
  output logic            word_end,
  output logic            last_end
);
  localparam logic [1:0] LAST_PH = 2'(BEATS_PER_WORD - 1);
  logic [NW_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      phase <= '0;
      idx   <= '0;
    end else if (phase == LAST_PH) begin
      phase <= '0;
      idx   <= idx + NW_W'(1);
    end else begin
      phase <= phase + 2'd1;
    end
  end

  assign word_end = run && (phase == LAST_PH);
  assign last_end = word_end && (idx == nwords - NW_W'(1));

  // R5: a burst never runs past its word count
  a_r5_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> idx < nwords);
endmodule

// File: rtl/dxc_top.sv
module dxc_top
  import dxc_pkg::*;
#(
  parameter int unsigned DW         = 16,
  parameter int unsigned WC_W       = 5,
  parameter int unsigned FIFO_DEPTH = 32,
  parameter int unsigned CLK_MHZ    = 50,
  parameter int unsigned TMO_US     = 10,
  parameter int unsigned TIE_CYC    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_strap_n,
  input  logic            op_start,
  input  logic            op_tx,
  input  logic            op_burst,
  input  logic [WC_W-1:0] op_wc,
  input  logic            rx_push,
  input  logic [DW-1:0]   rx_word,
  output logic [DW-1:0]   rd_data,
  output logic            rd_valid,
  output logic [DW-1:0]   cfg_word,
  output logic            cfg_valid,
  output logic            busy,
  output logic [WC_W-1:0] cur_wc,
  output logic            bus_req_n,
  input  logic            bus_gnt_n,
  output logic            bus_ack_n,
  output logic            term_act_n,
  output logic            hs_fail_n,
  output logic            mem_rd_n,
  output logic            mem_wr_n,
  input  logic [DW-1:0]   sys_din,
  output logic [DW-1:0]   sys_dout,
  output logic            sys_dout_en
);
  localparam int unsigned TMO_CYC = CLK_MHZ * TMO_US;
  localparam int unsigned NW_W    = WC_W + 1;
  localparam int unsigned FCW     = $clog2(FIFO_DEPTH + 1);

  dxc_state_e      st;
  dxc_mode_e       mode;
  logic [NW_W-1:0] total, widx, nwords_xfer;
  logic            fail, cfg_pend;

  // named internal events
  logic            run, writes, start_acc, capture, data_ready;
  logic            tmo_exp, tie_exp, word_end, last_end;
  logic [1:0]      phase;
  logic [FCW-1:0]  fifo_cnt;
  logic [DW-1:0]   fifo_dout;

  assign run         = (st == ST_XFER);
  assign writes      = mode_writes(mode);
  assign start_acc   = (st == ST_IDLE) && !cfg_pend && op_start;
  assign capture     = run && !writes && (phase == 2'd1);
  assign nwords_xfer = (mode == MD_RXB) ? total : NW_W'(1);

  always_comb begin
    case (mode)
      MD_RX:   data_ready = (fifo_cnt != '0);
      MD_RXB:  data_ready = (32'(fifo_cnt) >= 32'(total));
      default: data_ready = 1'b1;
    endcase
  end

  dxc_cycle_timer #(.LIMIT(TMO_CYC)) u_tmo (
    .clk(clk), .rst_n(rst_n), .en(st == ST_REQ), .expired(tmo_exp));

  dxc_cycle_timer #(.LIMIT(TIE_CYC)) u_tie (
    .clk(clk), .rst_n(rst_n), .en(st == ST_WAIT_HI), .expired(tie_exp));

  dxc_word_engine #(.NW_W(NW_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .run(run), .nwords(nwords_xfer),
    .phase(phase), .word_end(word_end), .last_end(last_end));

  dxc_rx_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(start_acc), .push(rx_push), .din(rx_word),
    .pop(word_end && writes), .dout(fifo_dout), .count(fifo_cnt));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      mode      <= MD_TX;
      total     <= '0;
      widx      <= '0;
      fail      <= 1'b0;
      cfg_pend  <= 1'b1;
      rd_data   <= '0;
      rd_valid  <= 1'b0;
      cfg_word  <= '0;
      cfg_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (capture) begin
        if (mode == MD_CFG) begin
          cfg_word  <= sys_din;
          cfg_valid <= 1'b1;
        end else begin
          rd_data  <= sys_din;
          rd_valid <= 1'b1;
        end
      end
      if (word_end) widx <= widx + NW_W'(1);

      case (st)
        ST_IDLE: begin
          if (cfg_pend) begin
            cfg_pend <= 1'b0;
            if (!cfg_strap_n) begin
              mode  <= MD_CFG;
              total <= NW_W'(1);
              widx  <= '0;
              st    <= ST_REQ;
            end
          end else if (op_start) begin
            mode  <= pick_mode(op_tx, op_burst);
            total <= NW_W'(wc_words(32'(op_wc), WC_W));
            widx  <= '0;
            fail  <= 1'b0;
            st    <= ST_WAIT_DATA;
          end
        end
        ST_WAIT_DATA: if (data_ready) st <= ST_REQ;
        ST_REQ: begin
          if (!bus_gnt_n) st <= ST_XFER;
          else if (tmo_exp) begin
            fail <= 1'b1;
            st   <= ST_IDLE;
          end
        end
        ST_XFER: if (last_end) st <= ST_REL;
        ST_REL:  st <= ST_WAIT_HI;
        ST_WAIT_HI: begin
          if (bus_gnt_n || tie_exp)
            st <= ((mode == MD_CFG) || (widx == total)) ? ST_IDLE : ST_WAIT_DATA;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign bus_req_n   = !((st == ST_REQ) || (st == ST_XFER) || (st == ST_REL));
  assign bus_ack_n   = !run;
  assign term_act_n  = !(run && (mode == MD_CFG));
  assign mem_rd_n    = !(run && !writes);
  assign mem_wr_n    = !(run && writes && (phase == 2'd1));
  assign sys_dout_en = run && writes;
  assign sys_dout    = fifo_dout;
  assign hs_fail_n   = !fail;
  assign busy        = (st != ST_IDLE);
  assign cur_wc      = widx[WC_W-1:0];

  // R2: bus ownership only under a standing request, entered from a sampled grant
  a_r2_ack_under_req: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ack_n |-> !bus_req_n);
  a_r2_ack_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_ack_n) |-> $past(!bus_gnt_n));
  // R3: a timeout leaves the bus fully released
  a_r3_fail_releases: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_fail_n) |-> bus_req_n && bus_ack_n);
  // R6: one-clock write strobe with data driven
  a_r6_wr_one_clk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |=> mem_wr_n);
  a_r6_wr_driven: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |-> sys_dout_en);
  // R7: read enable lasts three clocks
  a_r7_rd_three: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_rd_n) |=> !mem_rd_n ##1 !mem_rd_n ##1 mem_rd_n);
  // R9: request follows the acknowledge by one clock
  a_r9_req_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ack_n) |-> !bus_req_n ##1 bus_req_n);
  // R1: active-terminal only inside a configuration read window
  a_r1_act_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    !term_act_n |-> !bus_ack_n && !mem_rd_n);
  // R10: word index never passes the word count
  a_r10_idx_cap: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> widx <= total);
endmodule

// File: tb/dxc_top_tb.sv
module dxc_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 500;
  localparam int TIE        = 4;
  localparam int GNT_DLY    = 3;

  logic        clk = 0, rst_n = 0, cfg_strap_n = 0;
  logic        op_start = 0, op_tx = 0, op_burst = 0, rx_push = 0;
  logic [4:0]  op_wc = 0;
  logic [15:0] rx_word = 0, sys_din = 16'h1000;
  logic        bus_gnt_n = 1;
  logic [15:0] rd_data, cfg_word, sys_dout;
  logic        rd_valid, cfg_valid, busy, bus_req_n, bus_ack_n, term_act_n;
  logic        hs_fail_n, mem_rd_n, mem_wr_n, sys_dout_en;
  logic [4:0]  cur_wc;

  dxc_top #(.DW(16), .WC_W(5), .FIFO_DEPTH(32), .CLK_MHZ(50), .TMO_US(10), .TIE_CYC(TIE)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_strap_n(cfg_strap_n), .op_start(op_start),
    .op_tx(op_tx), .op_burst(op_burst), .op_wc(op_wc), .rx_push(rx_push),
    .rx_word(rx_word), .rd_data(rd_data), .rd_valid(rd_valid), .cfg_word(cfg_word),
    .cfg_valid(cfg_valid), .busy(busy), .cur_wc(cur_wc), .bus_req_n(bus_req_n),
    .bus_gnt_n(bus_gnt_n), .bus_ack_n(bus_ack_n), .term_act_n(term_act_n),
    .hs_fail_n(hs_fail_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .sys_din(sys_din), .sys_dout(sys_dout), .sys_dout_en(sys_dout_en));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, gnt_mode = 1, gd = 0, cyc = 0;
  int req_falls = 0, req_low_cyc = 0, ack_run = 0, last_ack_run = 0, ack_windows = 0;
  int hi_run = 0, last_hi_gap = 0, rd_run = 0, rd_cnt = 0, wr_cnt = 0, act_cyc = 0;
  int op_idx = 0, last_push_cyc = 0, last_reqfall_cyc = 0;
  int v_r2 = 0, v_r6 = 0, v_r7 = 0, v_r9 = 0, v_r10 = 0;
  logic        prev_req = 1, prev_ack = 1, prev_wr = 1, prev_busy = 0, chk_req_next = 0;
  logic [15:0] exp_rd = 0, nxt;
  logic [15:0] wr_log [64];

  // monitor, grant responder and data source, all away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (busy && !prev_busy) op_idx = 0;
    if (rx_push) last_push_cyc = cyc;
    if (prev_req && !bus_req_n) begin req_falls++; last_reqfall_cyc = cyc; end
    if (!bus_req_n) req_low_cyc++;
    if (!bus_ack_n) ack_run++;
    else if (ack_run != 0) begin last_ack_run = ack_run; ack_windows++; ack_run = 0; end
    if (bus_req_n) hi_run++;
    else if (hi_run != 0) begin last_hi_gap = hi_run; hi_run = 0; end
    if (chk_req_next) begin if (!bus_req_n) v_r9++; chk_req_next = 0; end
    if (!prev_ack && bus_ack_n) begin if (bus_req_n) v_r9++; chk_req_next = 1; end
    if (!bus_ack_n && (bus_req_n || bus_gnt_n)) v_r2++;
    if ((!mem_rd_n || !mem_wr_n || sys_dout_en) && bus_ack_n) v_r2++;
    if (!term_act_n) act_cyc++;
    nxt = sys_din + 16'h0111;
    if (!mem_rd_n) begin
      rd_run++;
      if (rd_run == 2) exp_rd = nxt;
    end else if (rd_run != 0) begin
      if (rd_run != 3) v_r7++;
      rd_run = 0;
    end
    if (rd_valid) begin
      rd_cnt++;
      if (rd_data !== exp_rd) v_r7++;
      if (cur_wc !== 5'(op_idx)) v_r10++;
      op_idx++;
    end
    if (!mem_wr_n) begin
      if (!sys_dout_en || !prev_wr) v_r6++;
      wr_log[wr_cnt % 64] = sys_dout;
      wr_cnt++;
    end
    sys_din <= nxt;
    case (gnt_mode)
      0: bus_gnt_n <= 1'b0;
      1: if (!bus_req_n) begin
           if (gd >= GNT_DLY) bus_gnt_n <= 1'b0; else gd++;
         end else begin gd = 0; bus_gnt_n <= 1'b1; end
      default: bus_gnt_n <= 1'b1;
    endcase
    prev_req = bus_req_n; prev_ack = bus_ack_n; prev_wr = mem_wr_n; prev_busy = busy;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_n <= 0; cfg_strap_n <= strap;
    repeat (3) @(negedge clk);
    rst_n <= 1;
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    repeat (2) @(negedge clk);
    while (busy && n < 3000) begin @(negedge clk); n++; end
    chk({tag, " completes"}, int'(busy), 0);
  endtask

  task automatic start_op(input logic tx, input logic burst, input logic [4:0] wc);
    @(negedge clk);
    op_tx <= tx; op_burst <= burst; op_wc <= wc; op_start <= 1;
    @(negedge clk);
    op_start <= 0;
  endtask

  task automatic push_word(input logic [15:0] w);
    @(negedge clk);
    rx_word <= w; rx_push <= 1;
    @(negedge clk);
    rx_push <= 0;
  endtask

  task automatic t_cfg_read();
    int a0, r0;
    a0 = act_cyc; r0 = req_falls;
    gnt_mode = 1;
    do_reset(1'b0);
    wait_idle("R1 cfg");
    chk("R1 cfg_valid", int'(cfg_valid), 1);
    chk("R1 cfg_word", int'(cfg_word), int'(exp_rd));
    chk("R1 active-terminal clocks", act_cyc - a0, 3);
    chk("R1 one request", req_falls - r0, 1);
  endtask

  task automatic t_strap_high();
    int r0;
    do_reset(1'b1);
    r0 = req_falls;
    @(negedge clk);
    chk("R1 reset req_n", int'(bus_req_n), 1);
    chk("R1 reset ack_n", int'(bus_ack_n), 1);
    chk("R1 reset strobes", int'({mem_rd_n, mem_wr_n, hs_fail_n}), 7);
    chk("R1 reset busy", int'(busy), 0);
    repeat (20) @(negedge clk);
    chk("R1 no request with strap high", req_falls - r0, 0);
    chk("R1 cfg_valid clear", int'(cfg_valid), 0);
  endtask

  task automatic t_tx_words();
    int rc0, rf0, aw0;
    rc0 = rd_cnt; rf0 = req_falls; aw0 = ack_windows;
    gnt_mode = 1;
    start_op(1'b1, 1'b1, 5'd3);
    wait_idle("R4 tx");
    chk("R7 words read", rd_cnt - rc0, 3);
    chk("R4 requests per word", req_falls - rf0, 3);
    chk("R4 windows per word", ack_windows - aw0, 3);
    chk("R4 window length", last_ack_run, 3);
    chk("R8 waits for grant high", last_hi_gap, 2);
    chk("R10 cur_wc at end", int'(cur_wc), 3);
  endtask

  task automatic t_rx_collide();
    int w0, aw0;
    w0 = wr_cnt; aw0 = ack_windows;
    gnt_mode = 1;
    start_op(1'b0, 1'b0, 5'd2);
    push_word(16'h1234);
    while (mem_wr_n) @(negedge clk);
    @(negedge clk);
    rx_word <= 16'hBEEF; rx_push <= 1;
    @(negedge clk);
    rx_push <= 0;
    wait_idle("R4 rx");
    chk("R6 words written", wr_cnt - w0, 2);
    chk("R6 first word", int'(wr_log[w0 % 64]), 16'h1234);
    chk("R6 second word", int'(wr_log[(w0 + 1) % 64]), 16'hBEEF);
    chk("R4 rx windows", ack_windows - aw0, 2);
  endtask

  task automatic t_rx_burst();
    int w0, aw0, rf0;
    w0 = wr_cnt; aw0 = ack_windows; rf0 = req_falls;
    gnt_mode = 1;
    start_op(1'b0, 1'b1, 5'd4);
    for (int i = 0; i < 4; i++) begin
      push_word(16'hA000 + 16'(i));
      repeat (3) @(negedge clk);
    end
    wait_idle("R5 burst");
    chk("R5 single request", req_falls - rf0, 1);
    chk("R5 single window", ack_windows - aw0, 1);
    chk("R5 window 3*N", last_ack_run, 12);
    chk("R5 request after last word", int'(last_reqfall_cyc > last_push_cyc), 1);
    chk("R6 burst words", wr_cnt - w0, 4);
    for (int i = 0; i < 4; i++)
      chk("R6 burst order", int'(wr_log[(w0 + i) % 64]), 16'hA000 + i);
  endtask

  task automatic t_timeout();
    int aw0, rl0, rc0;
    aw0 = ack_windows; rl0 = req_low_cyc;
    gnt_mode = 2;
    start_op(1'b1, 1'b0, 5'd1);
    wait_idle("R3 timeout");
    chk("R3 fail flag", int'(hs_fail_n), 0);
    chk("R3 request length", req_low_cyc - rl0, TMO);
    chk("R3 no acknowledge", ack_windows - aw0, 0);
    repeat (10) @(negedge clk);
    chk("R3 flag held", int'(hs_fail_n), 0);
    gnt_mode = 1;
    rc0 = rd_cnt;
    @(negedge clk);
    op_tx <= 1; op_wc <= 5'd1; op_start <= 1;
    @(negedge clk);
    op_start <= 0;
    chk("R3 flag cleared by start", int'(hs_fail_n), 1);
    wait_idle("R3 retry");
    chk("R3 retry reads", rd_cnt - rc0, 1);
  endtask

  task automatic t_tied_grant();
    int rc0;
    rc0 = rd_cnt;
    gnt_mode = 0;
    start_op(1'b1, 1'b0, 5'd2);
    wait_idle("R8 tied");
    chk("R8 tied reads", rd_cnt - rc0, 2);
    chk("R8 tied gap", last_hi_gap, TIE + 1);
  endtask

  task automatic t_wc_zero();
    int rc0;
    rc0 = rd_cnt;
    gnt_mode = 0;
    start_op(1'b1, 1'b0, 5'd0);
    wait_idle("R10 wc0");
    chk("R10 zero field is 32 words", rd_cnt - rc0, 32);
    chk("R10 cur_wc wraps", int'(cur_wc), 0);
  endtask

  task automatic t_start_busy();
    int rc0, w0;
    rc0 = rd_cnt; w0 = wr_cnt;
    gnt_mode = 1;
    start_op(1'b1, 1'b0, 5'd4);
    repeat (6) @(negedge clk);
    start_op(1'b0, 1'b1, 5'd1);
    wait_idle("R11 busy start");
    chk("R11 reads unchanged", rd_cnt - rc0, 4);
    chk("R11 no writes", wr_cnt - w0, 0);
    chk("R11 cur_wc", int'(cur_wc), 4);
  endtask

  bit done = 0;

  initial begin
    t_cfg_read();
    t_strap_high();
    t_tx_words();
    t_rx_collide();
    t_rx_burst();
    t_timeout();
    t_tied_grant();
    t_wc_zero();
    t_start_busy();
    chk("R2 grant ordering", v_r2, 0);
    chk("R6 write strobe", v_r6, 0);
    chk("R7 read cadence and data", v_r7, 0);
    chk("R9 request release", v_r9, 0);
    chk("R10 word index", v_r10, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule